// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter for a processor core. Each cycle the event sources deliver, for every event code, a set of small per-cycle occurrence counts. Each count belongs to one sub-condition of that event. The counter picks one event code and a mask of sub-conditions and adds up the selected counts. It can also add the counts reported for other cores or bus agents. Before anything reaches the accumulator, the counter applies a threshold compare with optional inversion, optional rising-edge detection, privilege-level filtering and a global enable.

Software programs the block through one write/read register port with three addresses: the select register, the 40-bit count value, and a sticky overflow flag. When the count wraps past all ones, the flag is set and drives an interrupt request. The request stays high until software clears the flag.

Top module: `qual_evt_counter`

## Requirements
- R1: After reset the count is 0, the select register reads 0 and `irq` is low.
- R2: Address 0 is the select register, read back zero-extended. Its field layout with default parameters is: event code in bits 1:0, sub-condition mask in bits 5:2, user-level enable in bit 6, level-0 enable in bit 7, edge mode in bit 8, wide source scope in bit 9, global enable in bit 10, invert in bit 11, threshold in bits 19:12. Address 1 is the count. Address 2 reads the overflow flag in bit 0. Address 3 reads 0.
- R3: The per-cycle event count is the sum, over the sub-conditions whose mask bit is set, of the chosen code's counts. With a threshold of zero and edge mode off, each enabled cycle adds that full sum to the count. Sub-condition j of code c lies at bit offset ((c*4)+j)*3 of the event inputs.
- R4: With a nonzero threshold, the count grows by exactly one in each enabled cycle whose event count is at least the threshold, and by nothing otherwise.
- R5: With a nonzero threshold and invert set, the count grows by one in each enabled cycle whose event count is below the threshold. Invert has no effect when the threshold is zero.
- R6: In edge mode the count grows by one only in a cycle where the qualified condition is true and was false in the previous cycle. The condition is the threshold compare, or a nonzero event count when the threshold is zero.
- R7: The previous-condition history is false after reset. It is cleared by every write to the select register, so a condition that stays true across a rewrite counts once more in the first cycle after the write.
- R8: Level-0 enable permits counting when `priv_lvl` is 0. User enable permits counting when `priv_lvl` is 1, 2 or 3. When both bits are clear, all levels count.
- R9: With wide scope clear only `evt_local` is summed. With it set, the selected counts of `evt_remote` are added as well.
- R10: With the global enable clear, the count does not change except by a software write.
- R11: A write to address 1 loads the written value at the next clock edge and replaces any increment in that cycle.
- R12: A carry out of the 40-bit count sets the sticky overflow flag, and `irq` follows the flag. Any write to address 2 clears the flag, but a carry in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_local | input | 48 | Per-cycle counts of this core, 3 bits per code and sub-condition |
| evt_remote | input | 48 | Per-cycle counts of other cores or agents, same layout |
| priv_lvl | input | 2 | Current privilege level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two functions can land on the same clock edge. One is a software action: a count load, or a flag clear. The other is the hardware increment or carry. The bench provokes the first case by loading the count while enabled events are present, and expects the loaded value with the increment discarded. It provokes the second by parking the count a few steps below the wrap and clearing the flag in the cycle that carries, and expects the flag to stay set. A reference model in the bench predicts every readback, including select rewrites in edge mode, where history clearing and an ongoing true condition meet.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    RA_SEL = 2'd0,
    RA_CNT = 2'd1,
    RA_OVF = 2'd2
  } reg_addr_e;

  // Qualifier control bits, lowest bit first: usr, os, edge_m, any_src, enable, inv
  typedef struct packed {
    logic inv;
    logic enable;
    logic any_src;
    logic edge_m;
    logic os;
    logic usr;
  } qual_ctl_t;

  localparam int QCTL_W = 6;

endpackage

// File: rtl/pmc_evt_select.sv
module pmc_evt_select #(
  parameter int NUM_CODES = 4,
  parameter int NUM_SUB   = 4,
  parameter int CNT_W     = 3,
  parameter int EVC_W     = 2,
  parameter int SUM_W     = 6
) (
  input  logic [EVC_W-1:0]                   code,
  input  logic [NUM_SUB-1:0]                 umask,
  input  logic                               any_src,
  input  logic [NUM_CODES*NUM_SUB*CNT_W-1:0] loc_evts,
  input  logic [NUM_CODES*NUM_SUB*CNT_W-1:0] rem_evts,
  output logic [SUM_W-1:0]                   evt_sum
);

  logic [SUM_W-1:0] lane_val [NUM_SUB];

  generate
    for (genvar j = 0; j < NUM_SUB; j++) begin : g_lane
      logic [CNT_W-1:0] loc_c;
      logic [CNT_W-1:0] rem_c;
      assign loc_c = loc_evts[(int'(code)*NUM_SUB + j)*CNT_W +: CNT_W];
      assign rem_c = rem_evts[(int'(code)*NUM_SUB + j)*CNT_W +: CNT_W];
      assign lane_val[j] = umask[j]
                         ? (SUM_W'(loc_c) + (any_src ? SUM_W'(rem_c) : '0))
                         : '0;
    end
  endgenerate

  always_comb begin
    evt_sum = '0;
    for (int j = 0; j < NUM_SUB; j++) begin
      evt_sum = evt_sum + lane_val[j];
    end
  end

endmodule

// File: rtl/pmc_qualifier.sv
module pmc_qualifier
  import pmc_pkg::*;
#(
  parameter int SUM_W = 6,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] evt_sum,
  input  logic [THR_W-1:0] thr,
  input  qual_ctl_t        ctl,
  input  logic [1:0]       priv_lvl,
  input  logic             clr_hist,
  output logic [SUM_W-1:0] inc
);

  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

  logic             cond_q, cond_d;
  logic             both_dflt, priv_ok, live, thr_on, ge, cond;
  logic [CMP_W-1:0] sum_x, thr_x;

  always_comb begin
    both_dflt = !ctl.os && !ctl.usr;
    priv_ok   = (priv_lvl == 2'd0) ? (ctl.os || both_dflt) : (ctl.usr || both_dflt);
    live      = ctl.enable && priv_ok;
    sum_x     = CMP_W'(evt_sum);
    thr_x     = CMP_W'(thr);
    thr_on    = (thr_x != '0);
    ge        = (sum_x >= thr_x);
    cond      = live && (thr_on ? (ge ^ ctl.inv) : (evt_sum != '0));
    if (!live) begin
      inc = '0;
    end else if (ctl.edge_m) begin
      inc = SUM_W'(cond && !cond_q);
    end else if (thr_on) begin
      inc = SUM_W'(cond);
    end else begin
      inc = evt_sum;
    end
    cond_d = clr_hist ? 1'b0 : cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
    end else begin
      cond_q <= cond_d;
    end
  end

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CTR_W = 40,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             ld_en,
  input  logic [CTR_W-1:0] ld_val,
  input  logic             ovf_clr,
  output logic [CTR_W-1:0] cnt_q,
  output logic             ovf_q
);

  logic [CTR_W:0]   sum_ext;
  logic [CTR_W-1:0] cnt_d;
  logic             cnt_ce, carry, ovf_d;

  always_comb begin
    sum_ext = {1'b0, cnt_q} + (CTR_W+1)'(inc);
    cnt_ce  = ld_en || (inc != '0);
    cnt_d   = ld_en ? ld_val : sum_ext[CTR_W-1:0];
    carry   = !ld_en && sum_ext[CTR_W];
    if (carry) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_ce) begin
        cnt_q <= cnt_d;
      end
      ovf_q <= ovf_d;
    end
  end

endmodule

// File: rtl/qual_evt_counter.sv
module qual_evt_counter
  import pmc_pkg::*;
#(
  parameter int NUM_CODES = 4,
  parameter int NUM_SUB   = 4,
  parameter int CNT_W     = 3,
  parameter int THR_W     = 8,
  parameter int CTR_W     = 40,
  localparam int EVC_W    = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1,
  localparam int EVT_W    = NUM_CODES * NUM_SUB * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_local,
  input  logic [EVT_W-1:0] evt_remote,
  input  logic [1:0]       priv_lvl,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CTR_W-1:0] reg_wdata,
  output logic [CTR_W-1:0] reg_rdata,
  output logic             irq
);

  localparam int UM_LSB = EVC_W;
  localparam int QC_LSB = UM_LSB + NUM_SUB;
  localparam int TH_LSB = QC_LSB + QCTL_W;
  localparam int SEL_W  = TH_LSB + THR_W;
  localparam int SUM_W  = CNT_W + 1 + ((NUM_SUB > 1) ? $clog2(NUM_SUB) : 1);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_we, cnt_we, ovf_we;
  qual_ctl_t        ctl;
  logic [SUM_W-1:0] evt_sum, inc;
  logic [CTR_W-1:0] cnt_q;
  logic             ovf_q;

  always_comb begin
    sel_we = reg_we && (reg_addr == RA_SEL);
    cnt_we = reg_we && (reg_addr == RA_CNT);
    ovf_we = reg_we && (reg_addr == RA_OVF);
    sel_d  = sel_we ? reg_wdata[SEL_W-1:0] : sel_q;
    ctl    = qual_ctl_t'(sel_q[QC_LSB +: QCTL_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  pmc_evt_select #(
    .NUM_CODES(NUM_CODES), .NUM_SUB(NUM_SUB), .CNT_W(CNT_W),
    .EVC_W(EVC_W), .SUM_W(SUM_W)
  ) u_sel (
    .code     (sel_q[EVC_W-1:0]),
    .umask    (sel_q[UM_LSB +: NUM_SUB]),
    .any_src  (ctl.any_src),
    .loc_evts (evt_local),
    .rem_evts (evt_remote),
    .evt_sum  (evt_sum)
  );

  pmc_qualifier #(.SUM_W(SUM_W), .THR_W(THR_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_sum  (evt_sum),
    .thr      (sel_q[TH_LSB +: THR_W]),
    .ctl      (ctl),
    .priv_lvl (priv_lvl),
    .clr_hist (sel_we),
    .inc      (inc)
  );

  pmc_accum #(.CTR_W(CTR_W), .INC_W(SUM_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .ld_en   (cnt_we),
    .ld_val  (reg_wdata),
    .ovf_clr (ovf_we),
    .cnt_q   (cnt_q),
    .ovf_q   (ovf_q)
  );

  always_comb begin
    case (reg_addr)
      RA_SEL:  reg_rdata = CTR_W'(sel_q);
      RA_CNT:  reg_rdata = cnt_q;
      RA_OVF:  reg_rdata = CTR_W'(ovf_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = ovf_q;

endmodule

// File: rtl/qual_evt_counter_chk.sv
module qual_evt_counter_chk
  import pmc_pkg::*;
#(
  parameter int CTR_W  = 40,
  parameter int SEL_W  = 20,
  parameter int QC_LSB = 6,
  parameter int TH_LSB = 12,
  parameter int THR_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CTR_W-1:0] reg_wdata,
  input logic [CTR_W-1:0] cnt_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             irq
);

  logic      wr_cnt, wr_ovf, thr_nz;
  qual_ctl_t ctl;

  always_comb begin
    wr_cnt = reg_we && (reg_addr == 2'd1);
    wr_ovf = reg_we && (reg_addr == 2'd2);
    ctl    = qual_ctl_t'(sel_q[QC_LSB +: QCTL_W]);
    thr_nz = (sel_q[TH_LSB +: THR_W] != '0);
  end

  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(reg_wdata))); // R11

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.enable && !wr_cnt) |=> $stable(cnt_q)); // R10

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.edge_m && !wr_cnt) |=> ((cnt_q - $past(cnt_q)) <= CTR_W'(1))); // R6

  AST_THR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_nz && !wr_cnt) |=> ((cnt_q - $past(cnt_q)) <= CTR_W'(1))); // R4

  AST_WRAP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt) |=> ((cnt_q >= $past(cnt_q)) || irq)); // R12

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ovf) |=> irq); // R12

endmodule

bind qual_evt_counter qual_evt_counter_chk #(
  .CTR_W(CTR_W), .SEL_W(SEL_W), .QC_LSB(QC_LSB), .TH_LSB(TH_LSB), .THR_W(THR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cnt_q     (cnt_q),
  .sel_q     (sel_q),
  .irq       (irq)
);

// File: tb/qual_evt_counter_bench.sv
module qual_evt_counter_bench;

  logic        clk;
  logic        rst_n;
  logic [47:0] evt_local, evt_remote;
  logic [1:0]  priv_lvl;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [39:0] reg_wdata;
  logic [39:0] reg_rdata;
  logic        irq;

  qual_evt_counter u_qual_evt_counter (
    .clk(clk), .rst_n(rst_n), .evt_local(evt_local), .evt_remote(evt_remote),
    .priv_lvl(priv_lvl), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [39:0] rd;
    logic        irq_e;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  int loc[4][4];
  int rem[4][4];

  logic [19:0] m_sel;
  logic [39:0] m_cnt;
  logic        m_ovf;
  logic        m_prev;

  function automatic logic [39:0] mk_sel(int code, int um, bit usr, bit os, bit edg,
                                         bit any, bit en, bit inv, int thr);
    logic [39:0] s;
    s = '0;
    s[1:0]   = code[1:0];
    s[5:2]   = um[3:0];
    s[6]     = usr;
    s[7]     = os;
    s[8]     = edg;
    s[9]     = any;
    s[10]    = en;
    s[11]    = inv;
    s[19:12] = thr[7:0];
    return s;
  endfunction

  function automatic logic [47:0] pack(input bit remote);
    logic [47:0] f;
    f = '0;
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 4; j++)
        f[((c*4)+j)*3 +: 3] = remote ? rem[c][j][2:0] : loc[c][j][2:0];
    return f;
  endfunction

  task automatic clr_ev();
    for (int c = 0; c < 4; c++)
      for (int j = 0; j < 4; j++) begin
        loc[c][j] = 0;
        rem[c][j] = 0;
      end
  endtask

  // Driver: applies one cycle of stimulus at the falling edge and pushes the
  // readback expected after the following rising edge.
  task automatic drive(input bit we, input logic [1:0] addr, input logic [39:0] wd,
                       input logic [1:0] pv, input string tag);
    int code, sum, thr;
    bit usr, os, edg, any, en, inv, both, ok, live, cond;
    logic [40:0] t;
    int add;
    exp_t e;
    @(negedge clk);
    reg_we     = we;
    reg_addr   = addr;
    reg_wdata  = wd;
    priv_lvl   = pv;
    evt_local  = pack(0);
    evt_remote = pack(1);
    code = int'(m_sel[1:0]);
    usr  = m_sel[6];  os  = m_sel[7];  edg = m_sel[8];
    any  = m_sel[9];  en  = m_sel[10]; inv = m_sel[11];
    thr  = int'(m_sel[19:12]);
    sum  = 0;
    for (int j = 0; j < 4; j++)
      if (m_sel[2+j]) sum += loc[code][j] + (any ? rem[code][j] : 0);
    both = !usr && !os;
    ok   = (pv == 2'd0) ? (os || both) : (usr || both);
    live = en && ok;
    if (thr != 0) cond = live && ((sum >= thr) != inv);
    else          cond = live && (sum != 0);
    if (!live)         add = 0;
    else if (edg)      add = (cond && !m_prev) ? 1 : 0;
    else if (thr != 0) add = cond ? 1 : 0;
    else               add = sum;
    m_prev = (we && addr == 2'd0) ? 1'b0 : cond;
    t = {1'b0, m_cnt} + 41'(add);
    if (we && addr == 2'd1) begin
      m_cnt = wd;
    end else begin
      m_cnt = t[39:0];
      if (t[40]) m_ovf = 1'b1;
      else if (we && addr == 2'd2) m_ovf = 1'b0;
    end
    if (we && addr == 2'd2 && (we && addr != 2'd1) && !t[40]) m_ovf = 1'b0;
    if (we && addr == 2'd0) m_sel = wd[19:0];
    case (addr)
      2'd0:    e.rd = 40'(m_sel);
      2'd1:    e.rd = m_cnt;
      2'd2:    e.rd = 40'(m_ovf);
      default: e.rd = '0;
    endcase
    e.irq_e = m_ovf;
    e.tag   = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input logic [1:0] pv, input string tag);
    drive(0, 2'd1, '0, pv, tag);
  endtask

  // Monitor: samples one time unit after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (reg_rdata !== e.rd || irq !== e.irq_e) begin
        n_errors++;
        $display("FAIL %s: rdata=%0h irq=%0b expected rdata=%0h irq=%0b",
                 e.tag, reg_rdata, irq, e.rd, e.irq_e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    clr_ev();
    m_sel = '0; m_cnt = '0; m_ovf = 1'b0; m_prev = 1'b0;
    rst_n = 1'b0; reg_we = 0; reg_addr = 2'd1; reg_wdata = '0; priv_lvl = 2'd0;
    evt_local = '0; evt_remote = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    idle(0, "R1 count");
    drive(0, 2'd0, '0, 0, "R1 select");
    drive(0, 2'd2, '0, 0, "R1 flag");

    // R2: select write and readback; address 3 reads zero
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 0, 1, 0, 0), 0, "R2 write");
    drive(0, 2'd0, '0, 0, "R2 readback");
    drive(0, 2'd3, '0, 0, "R2 unused addr");

    // R3: masked union summed, other code ignored
    loc[1][0] = 2; loc[1][1] = 3; loc[1][2] = 4; loc[0][0] = 5;
    repeat (3) idle(0, "R3 raw sum");

    // R9: remote counts only with wide scope
    rem[1][0] = 1; rem[1][2] = 2;
    idle(0, "R9 scope off");
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 1, 1, 0, 0), 0, "R9 write");
    idle(0, "R9 scope on");
    idle(0, "R9 scope on");

    // R4: threshold compare
    clr_ev();
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 0, 1, 0, 4), 0, "R4 write");
    loc[1][0] = 1; loc[1][1] = 2; idle(0, "R4 below");
    loc[1][1] = 3; idle(0, "R4 equal");
    loc[1][1] = 4; idle(0, "R4 above");

    // R5: inverted threshold
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 0, 1, 1, 4), 0, "R5 write");
    loc[1][1] = 2; idle(0, "R5 below");
    loc[1][1] = 3; idle(0, "R5 equal");
    loc[1][1] = 0; idle(0, "R5 zero");
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 0, 1, 1, 0), 0, "R5 inv no thr");
    loc[1][1] = 3; idle(0, "R5 inv ignored");

    // R6: edge mode
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 1, 0, 1, 0, 4), 0, "R6 write");
    repeat (3) idle(0, "R6 held true");
    loc[1][1] = 0; idle(0, "R6 false");
    loc[1][1] = 3; idle(0, "R6 rise");
    idle(0, "R6 held");

    // R7: select rewrite clears history
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 1, 0, 1, 0, 4), 0, "R7 rewrite");
    idle(0, "R7 after rewrite");
    idle(0, "R7 held");
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 1, 0, 1, 0, 0), 0, "R7 edge no thr");
    idle(0, "R7 nonzero edge");
    idle(0, "R7 nonzero held");

    // R8: privilege filtering
    drive(1, 2'd0, mk_sel(1, 4'b0011, 0, 1, 0, 0, 1, 0, 0), 0, "R8 os only");
    idle(0, "R8 os at 0");
    idle(3, "R8 os at 3");
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 0, 0, 0, 1, 0, 0), 0, "R8 usr only");
    idle(0, "R8 usr at 0");
    idle(1, "R8 usr at 1");
    idle(2, "R8 usr at 2");
    drive(1, 2'd0, mk_sel(1, 4'b0011, 0, 0, 0, 0, 1, 0, 0), 0, "R8 neither");
    idle(0, "R8 default at 0");
    idle(3, "R8 default at 3");

    // R10: global enable off
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 0, 0, 0, 0), 0, "R10 disable");
    repeat (3) idle(0, "R10 hold");

    // R11: load overrides increment
    drive(1, 2'd0, mk_sel(1, 4'b0011, 1, 1, 0, 0, 1, 0, 0), 0, "R11 enable");
    drive(1, 2'd1, 40'd100, 0, "R11 load");
    idle(0, "R11 after load");

    // R12: wrap, sticky flag, clear, clear colliding with carry
    drive(1, 2'd1, 40'hFF_FFFF_FFFD, 0, "R12 park");
    idle(0, "R12 wrap");
    idle(0, "R12 sticky");
    drive(1, 2'd2, '0, 0, "R12 clear");
    idle(0, "R12 cleared");
    drive(1, 2'd1, 40'hFF_FFFF_FFFE, 0, "R12 park2");
    drive(1, 2'd2, '0, 0, "R12 clear vs carry");
    idle(0, "R12 still set");

    // Mixed patterns across modes
    for (int k = 0; k < 60; k++) begin
      for (int c = 0; c < 4; c++)
        for (int j = 0; j < 4; j++) begin
          loc[c][j] = int'($urandom_range(0, 4));
          rem[c][j] = int'($urandom_range(0, 4));
        end
      if (k % 10 == 0)
        drive(1, 2'd0, mk_sel(k % 4, (k * 7) % 16, k % 3 == 0, k % 4 == 0,
                              (k / 10) % 2 == 1, k % 20 == 0, 1, (k / 20) % 2 == 1,
                              (k % 30 == 0) ? 0 : 6), 0, "R3 R4 R6 mixed write");
      else
        idle(2'(k % 4), "R3 R5 R8 R9 mixed");
    end

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule